// File: doc/BRIEF.md
# Structural-Address Temporal Prefetch Engine

This block watches the stream of demand addresses that missed in the data cache. Each miss address is a physical line address. The block gives every new miss address a structural address. Misses that follow each other in time receive consecutive structural addresses, so a recorded stream can be replayed by stepping the structural address by one. The mappings are held in two small set-associative tables. One maps a physical line to its structural address (forward table). The other maps a structural address back to its physical line (reverse table). Each table entry holds one mapping.

On every miss a small state machine runs through these steps:

- It resolves the structural address S of the miss, allocating one if the address has never been seen.
- It offers a data prefetch for the physical line recorded at S+1.
- It checks whether the mapping for S+2 is on-chip. If that mapping is absent, the engine asks off-chip metadata storage for it.

A Bloom filter of keys allocated since reset screens each of these metadata reads. A read is sent only when its key may have been allocated. Mappings evicted from the reverse table leave on a writeback port. Metadata replies return the requested key together with the physical line, and are written into both tables.

The state machine has five states. **IDLE** accepts a miss (transition *accept*). **FIND** looks up the forward table and goes to PREF on a hit (*found*) or to ALLOC on a miss (*unknown*). **ALLOC** picks and writes the new mapping (*allocated*, to PREF). **PREF** offers the data prefetch (*step*, to AHEAD). **AHEAD** decides on the metadata request (*done*, back to IDLE). The prefetch and metadata request ports are valid/ready. An offer that is not taken in its single cycle is lost, and the engine never waits.

Top module: `stream_prefetch_engine`

## Requirements
- R1: After reset, miss_ready is 1, and pf_valid, mreq_valid and wb_valid are 0.
- R2: An unmapped miss receives structural address L+1, where L is the structural address of the previous miss. If there was no previous miss since reset, or if L+1 is already in the reverse table, it instead receives the smallest multiple of 16 that is at least one above the largest structural address allocated since reset (0 right after reset). The new mapping goes into both tables.
- R3: When the miss has structural address S and the reverse table holds S+1, pf_valid is high for exactly one cycle, in the PREF state, with pf_addr equal to the physical line recorded at S+1. Otherwise there is no prefetch for that miss.
- R4: When the reverse table lacks S+2 and the Bloom filter reports S+2, mreq_valid is high for one cycle, in the AHEAD state, with mreq_key equal to S+2. No request is made when S+2 is on-chip.
- R5: The Bloom filter has 1024 bits and two hashes of the 16-bit key k. Hash one XORs bit k[i] into bit (i mod 10). Hash two XORs bit k[i] into bit ((3i+1) mod 10). A key is reported only when both indexed bits are set. Keys are inserted only on allocation, and the bits are cleared only by reset.
- R6: Each table is 4-way set-associative with 16 sets, and the set is the key's low 4 bits. Replacement picks an invalid way first, otherwise the least recently used way. A write counts as a use. A forward-table hit in FIND counts as a use, and so does a reverse-table hit in PREF.
- R7: When the reverse table evicts an entry, wb_valid is high for one cycle with the evicted structural address and physical line.
- R8: A reply is accepted only when its key equals the key of the last request that completed a handshake and that has not yet been answered. An accepted reply is written into both tables. Any other reply leaves both tables unchanged.
- R9: An offer made while its ready is low is dropped. A dropped metadata request does not become outstanding. The engine does not wait for ready in either case.
- R10: miss_ready drops for 3 cycles after a mapped miss is accepted, and for 4 cycles after an unmapped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| miss_valid | input | 1 | Demand miss present |
| miss_addr | input | 20 | Physical line address of the miss |
| miss_ready | output | 1 | Engine is idle and takes the miss |
| pf_valid | output | 1 | Data prefetch offered |
| pf_addr | output | 20 | Physical line to prefetch |
| pf_ready | input | 1 | Prefetch taken |
| mreq_valid | output | 1 | Metadata read offered |
| mreq_key | output | 16 | Structural address whose mapping is wanted |
| mreq_ready | input | 1 | Metadata read taken |
| mrsp_valid | input | 1 | Metadata reply present |
| mrsp_key | input | 16 | Structural address of the reply |
| mrsp_phys | input | 20 | Physical line of the reply |
| wb_valid | output | 1 | Evicted mapping present |
| wb_key | output | 16 | Evicted structural address |
| wb_phys | output | 20 | Evicted physical line |

## Verification
Three training streams are recorded. The second and third are started after a replayed miss, which forces fresh aligned bases and so separates the continuation rule from the realignment rule. Seeded random replays of the trained lines then distinguish prefetches inside a stream from prefetches at a stream end. The random replays also separate on-chip S+2 keys from off-chip keys that the Bloom filter rejects. A directed run of 80 misses overflows every set of both tables, with one set touched part-way through, so the writeback order shows real LRU rather than plain FIFO. The same run creates an evicted-but-known key. Replies to that key are then sent with no request outstanding, with a wrong key, and with the right key. Later prefetches show which of these replies reached the tables.

// File: rtl/spe_pkg.sv
package spe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIND,
        ST_ALLOC,
        ST_PREF,
        ST_AHEAD
    } spe_state_e;
endpackage

// File: rtl/spe_meta_cache.sv
module spe_meta_cache #(
    parameter int KW   = 16,
    parameter int VW   = 20,
    parameter int WAYS = 4,
    parameter int SETS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [KW-1:0] rd_key,
    input  logic          rd_touch,
    output logic          rd_hit,
    output logic [VW-1:0] rd_val,
    input  logic          wr_en,
    input  logic [KW-1:0] wr_key,
    input  logic [VW-1:0] wr_val,
    output logic          ev_valid,
    output logic [KW-1:0] ev_key,
    output logic [VW-1:0] ev_val
);
    localparam int IW = $clog2(SETS);
    localparam int TW = KW - IW;
    localparam int AW = $clog2(WAYS);

    logic [TW-1:0] tag_q [SETS][WAYS];
    logic [VW-1:0] val_q [SETS][WAYS];
    logic          vld_q [SETS][WAYS];
    logic [AW-1:0] age_q [SETS][WAYS];

    logic [IW-1:0] rd_set, wr_set, tch_set;
    logic [TW-1:0] rd_tag, wr_tag;
    logic [WAYS-1:0] rd_hv, wr_hv, wr_inv;
    logic [AW-1:0] rd_way, wr_way, tch_way;
    logic tch_en;

    assign rd_set = rd_key[IW-1:0];
    assign rd_tag = rd_key[KW-1:IW];
    assign wr_set = wr_key[IW-1:0];
    assign wr_tag = wr_key[KW-1:IW];

    always_comb begin
        rd_hv  = '0;
        wr_hv  = '0;
        wr_inv = '0;
        rd_way = '0;
        rd_val = '0;
        for (int w = 0; w < WAYS; w++) begin
            rd_hv[w]  = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
            wr_hv[w]  = vld_q[wr_set][w] && (tag_q[wr_set][w] == wr_tag);
            wr_inv[w] = !vld_q[wr_set][w];
            if (rd_hv[w]) begin
                rd_way = AW'(w);
                rd_val = val_q[rd_set][w];
            end
        end
        rd_hit = |rd_hv;
        // victim choice: matching way, else first invalid, else oldest
        wr_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (age_q[wr_set][w] == AW'(WAYS - 1)) wr_way = AW'(w);
        for (int w = WAYS - 1; w >= 0; w--)
            if (wr_inv[w]) wr_way = AW'(w);
        for (int w = 0; w < WAYS; w++)
            if (wr_hv[w]) wr_way = AW'(w);
        ev_valid = wr_en && !(|wr_hv) && !wr_inv[wr_way];
        ev_key   = {tag_q[wr_set][wr_way], wr_set};
        ev_val   = val_q[wr_set][wr_way];
        tch_en   = wr_en || (rd_touch && rd_hit);
        tch_set  = wr_en ? wr_set : rd_set;
        tch_way  = wr_en ? wr_way : rd_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[s][w] <= 1'b0;
                    tag_q[s][w] <= '0;
                    val_q[s][w] <= '0;
                    age_q[s][w] <= AW'(w);
                end
            end
        end else begin
            if (wr_en) begin
                vld_q[wr_set][wr_way] <= 1'b1;
                tag_q[wr_set][wr_way] <= wr_tag;
                val_q[wr_set][wr_way] <= wr_val;
            end
            if (tch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (AW'(w) == tch_way)
                        age_q[tch_set][w] <= '0;
                    else if (age_q[tch_set][w] < age_q[tch_set][tch_way])
                        age_q[tch_set][w] <= age_q[tch_set][w] + 1'b1;
                end
            end
        end
    end

    // one mapping per key: a lookup never matches two ways
    assert_unique_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hv));
    // a written key is found on the next lookup of that key
    assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_key == wr_key) |=> (rd_key != $past(wr_key)) || rd_hit);
endmodule

// File: rtl/spe_bloom.sv
module spe_bloom #(
    parameter int KW   = 16,
    parameter int BITS = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_en,
    input  logic [KW-1:0] ins_key,
    input  logic [KW-1:0] q_key,
    output logic          q_hit
);
    localparam int HW = $clog2(BITS);

    function automatic logic [HW-1:0] fold(input logic [KW-1:0] k, input int mul, input int off);
        logic [HW-1:0] h;
        h = '0;
        for (int i = 0; i < KW; i++) h[(i * mul + off) % HW] ^= k[i];
        return h;
    endfunction

    logic [BITS-1:0] vec_q;
    logic [HW-1:0] ih1, ih2, qh1, qh2;

    assign ih1   = fold(ins_key, 1, 0);
    assign ih2   = fold(ins_key, 3, 1);
    assign qh1   = fold(q_key, 1, 0);
    assign qh2   = fold(q_key, 3, 1);
    assign q_hit = vec_q[qh1] && vec_q[qh2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else if (ins_en) begin
            vec_q[ih1] <= 1'b1;
            vec_q[ih2] <= 1'b1;
        end
    end

    // bits set by an insertion stay set
    assert_bloom_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> vec_q[$past(ih1)] && vec_q[$past(ih2)]);
endmodule

// File: rtl/stream_prefetch_engine.sv
module stream_prefetch_engine #(
    parameter int PW         = 20,
    parameter int SW         = 16,
    parameter int WAYS       = 4,
    parameter int SETS       = 16,
    parameter int BLOOM_BITS = 1024,
    parameter int ALIGN      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [PW-1:0] miss_addr,
    output logic          miss_ready,
    output logic          pf_valid,
    output logic [PW-1:0] pf_addr,
    input  logic          pf_ready,
    output logic          mreq_valid,
    output logic [SW-1:0] mreq_key,
    input  logic          mreq_ready,
    input  logic          mrsp_valid,
    input  logic [SW-1:0] mrsp_key,
    input  logic [PW-1:0] mrsp_phys,
    output logic          wb_valid,
    output logic [SW-1:0] wb_key,
    output logic [PW-1:0] wb_phys
);
    import spe_pkg::*;

    localparam logic [SW-1:0] ALN_M = SW'(ALIGN - 1);

    spe_state_e state_q, state_d;
    logic [PW-1:0] miss_p_q;
    logic [SW-1:0] cur_s_q, last_s_q, hw_q, pend_k_q, fill_k_q;
    logic [PW-1:0] fill_p_q;
    logic last_v_q, pend_v_q, fill_v_q;

    logic          fwd_hit, rev_hit, fwd_wr, rev_wr, bl_hit, rsp_match;
    logic [SW-1:0] fwd_val, rev_key, fwd_wr_v, rev_wr_k, cand_s, fresh_s, alloc_s;
    logic [PW-1:0] rev_val, fwd_wr_k, rev_wr_v;
    logic          fwd_ev_v, unused_ok;
    logic [PW-1:0] fwd_ev_k;
    logic [SW-1:0] fwd_ev_val;

    assign cand_s    = last_s_q + 1'b1;
    assign fresh_s   = (hw_q + ALN_M) & ~ALN_M;
    assign alloc_s   = (last_v_q && !rev_hit) ? cand_s : fresh_s;
    assign rsp_match = mrsp_valid && pend_v_q && (mrsp_key == pend_k_q);
    assign unused_ok = 1'b1;

    always_comb begin
        unique case (state_q)
            ST_ALLOC: rev_key = cand_s;
            ST_AHEAD: rev_key = cur_s_q + SW'(2);
            default:  rev_key = cur_s_q + 1'b1;
        endcase
        fwd_wr   = (state_q == ST_ALLOC) || fill_v_q;
        rev_wr   = fwd_wr;
        fwd_wr_k = (state_q == ST_ALLOC) ? miss_p_q : fill_p_q;
        fwd_wr_v = (state_q == ST_ALLOC) ? alloc_s  : fill_k_q;
        rev_wr_k = fwd_wr_v;
        rev_wr_v = fwd_wr_k;
    end

    spe_meta_cache #(.KW(PW), .VW(SW), .WAYS(WAYS), .SETS(SETS)) u_fwd (
        .clk(clk), .rst_n(rst_n),
        .rd_key(miss_p_q), .rd_touch(state_q == ST_FIND), .rd_hit(fwd_hit), .rd_val(fwd_val),
        .wr_en(fwd_wr), .wr_key(fwd_wr_k), .wr_val(fwd_wr_v),
        .ev_valid(fwd_ev_v), .ev_key(fwd_ev_k), .ev_val(fwd_ev_val));

    spe_meta_cache #(.KW(SW), .VW(PW), .WAYS(WAYS), .SETS(SETS)) u_rev (
        .clk(clk), .rst_n(rst_n),
        .rd_key(rev_key), .rd_touch(state_q == ST_PREF), .rd_hit(rev_hit), .rd_val(rev_val),
        .wr_en(rev_wr), .wr_key(rev_wr_k), .wr_val(rev_wr_v),
        .ev_valid(wb_valid), .ev_key(wb_key), .ev_val(wb_phys));

    spe_bloom #(.KW(SW), .BITS(BLOOM_BITS)) u_bloom (
        .clk(clk), .rst_n(rst_n),
        .ins_en(state_q == ST_ALLOC), .ins_key(alloc_s),
        .q_key(cur_s_q + SW'(2)), .q_hit(bl_hit));

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_valid) state_d = ST_FIND;
            ST_FIND:  state_d = fwd_hit ? ST_PREF : ST_ALLOC;
            ST_ALLOC: state_d = ST_PREF;
            ST_PREF:  state_d = ST_AHEAD;
            ST_AHEAD: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        miss_ready = (state_q == ST_IDLE);
        pf_valid   = (state_q == ST_PREF) && rev_hit;
        pf_addr    = rev_val;
        mreq_valid = (state_q == ST_AHEAD) && !rev_hit && bl_hit;
        mreq_key   = cur_s_q + SW'(2);
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            miss_p_q <= '0;
            cur_s_q  <= '0;
            last_s_q <= '0;
            last_v_q <= 1'b0;
            hw_q     <= '0;
            pend_v_q <= 1'b0;
            pend_k_q <= '0;
            fill_v_q <= 1'b0;
            fill_k_q <= '0;
            fill_p_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && miss_valid) miss_p_q <= miss_addr;
            if (state_q == ST_FIND && fwd_hit) begin
                cur_s_q  <= fwd_val;
                last_s_q <= fwd_val;
                last_v_q <= 1'b1;
            end
            if (state_q == ST_ALLOC) begin
                cur_s_q  <= alloc_s;
                last_s_q <= alloc_s;
                last_v_q <= 1'b1;
                if (alloc_s + 1'b1 > hw_q) hw_q <= alloc_s + 1'b1;
            end
            if (fill_v_q && state_q != ST_ALLOC) fill_v_q <= 1'b0;
            if (rsp_match) begin
                pend_v_q <= 1'b0;
                fill_v_q <= 1'b1;
                fill_k_q <= mrsp_key;
                fill_p_q <= mrsp_phys;
            end
            if (mreq_valid && mreq_ready) begin
                pend_v_q <= 1'b1;
                pend_k_q <= mreq_key;
            end
        end
    end

    assert_pf_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |=> !pf_valid);
    assert_mreq_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |=> !mreq_valid);
    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);
    assert_reply_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_match && !(mreq_valid && mreq_ready)) |=> !pend_v_q && fill_v_q);
    assert_no_pending_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready && !pend_v_q && !rsp_match) |=> !pend_v_q);
    assert_fwd_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_ev_v |-> unused_ok && (fwd_ev_k != fwd_wr_k) && !$isunknown(fwd_ev_val));
endmodule

// File: tb/stream_prefetch_engine_test.sv
`timescale 1ns/1ps
module stream_prefetch_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0;
    logic [19:0] miss_addr = '0;
    logic miss_ready, pf_valid, mreq_valid, wb_valid;
    logic [19:0] pf_addr, wb_phys;
    logic [15:0] mreq_key, wb_key;
    logic pf_ready = 1'b1;
    logic mreq_ready = 1'b1;
    logic mrsp_valid = 1'b0;
    logic [15:0] mrsp_key = '0;
    logic [19:0] mrsp_phys = '0;

    always #4 clk = ~clk;

    stream_prefetch_engine uut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready),
        .mreq_valid(mreq_valid), .mreq_key(mreq_key), .mreq_ready(mreq_ready),
        .mrsp_valid(mrsp_valid), .mrsp_key(mrsp_key), .mrsp_phys(mrsp_phys),
        .wb_valid(wb_valid), .wb_key(wb_key), .wb_phys(wb_phys));

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model built from the requirements
    int m_fwd [int];
    int m_rev [int];
    bit [1023:0] m_bloom;
    int m_last;
    bit m_last_v;
    int m_hw;
    int wb_k_q [$];
    int wb_p_q [$];

    always @(negedge clk) if (rst_n && wb_valid) begin
        wb_k_q.push_back(int'(wb_key));
        wb_p_q.push_back(int'(wb_phys));
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int hsh(input int k, input int mul, input int off);
        bit [9:0] h = '0;
        for (int i = 0; i < 16; i++) h[(i * mul + off) % 10] ^= k[i];
        return int'(h);
    endfunction

    function automatic bit bloom_has(input int k);
        return m_bloom[hsh(k, 1, 0)] && m_bloom[hsh(k, 3, 1)];
    endfunction

    task automatic model_miss(input int p, output int s, output bit alloc);
        alloc = !m_fwd.exists(p);
        if (!alloc) s = m_fwd[p];
        else begin
            if (m_last_v && !m_rev.exists(m_last + 1)) s = m_last + 1;
            else s = (m_hw + 15) & ~15;
            m_fwd[p] = s;
            m_rev[s] = p;
            if (s + 1 > m_hw) m_hw = s + 1;
            m_bloom[hsh(s, 1, 0)] = 1'b1;
            m_bloom[hsh(s, 3, 1)] = 1'b1;
        end
        m_last = s;
        m_last_v = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_fwd.delete();
        m_rev.delete();
        m_bloom = '0;
        m_last = 0;
        m_last_v = 1'b0;
        m_hw = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(miss_ready == 1'b1, "R1", "miss_ready after reset", int'(miss_ready), 1);
        check(!pf_valid && !mreq_valid && !wb_valid, "R1", "outputs idle after reset",
              int'({pf_valid, mreq_valid, wb_valid}), 0);
    endtask

    // one miss, checked for prefetch, metadata request and busy time
    task automatic send_miss(input int p);
        int s, busy, pf_n, pf_a, mq_n, mq_k;
        bit alloc, e_pf, e_mq;
        model_miss(p, s, alloc);
        e_pf = m_rev.exists(s + 1);
        e_mq = !m_rev.exists(s + 2) && bloom_has(s + 2);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr = 20'(p);
        @(posedge clk);
        busy = 0; pf_n = 0; pf_a = 0; mq_n = 0; mq_k = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            miss_valid = 1'b0;
            if (miss_ready) break;
            busy++;
            if (pf_valid) begin pf_n++; pf_a = int'(pf_addr); end
            if (mreq_valid) begin mq_n++; mq_k = int'(mreq_key); end
        end
        check(busy == (alloc ? 4 : 3), "R10", "busy cycles", busy, alloc ? 4 : 3);
        check(pf_n == (e_pf ? 1 : 0), "R3", "prefetch count", pf_n, e_pf ? 1 : 0);
        if (e_pf) check(pf_a == m_rev[s + 1], "R3", "prefetch line", pf_a, m_rev[s + 1]);
        check(mq_n == (e_mq ? 1 : 0), "R4", "metadata request count", mq_n, e_mq ? 1 : 0);
        if (e_mq) check(mq_k == s + 2, "R4", "metadata request key", mq_k, s + 2);
    endtask

    task automatic send_rsp(input int k, input int p);
        @(negedge clk);
        mrsp_valid = 1'b1;
        mrsp_key = 16'(k);
        mrsp_phys = 20'(p);
        @(negedge clk);
        mrsp_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        int k;
        seed = 32'h5eed_0017;
        void'($urandom(seed));

        // phase B: three trained streams, then seeded random replays (R2 R3 R4 R5)
        do_reset();
        for (int i = 0; i < 8; i++) send_miss(20'h2000 + i * 7);
        send_miss(20'h2000 + 2 * 7);
        for (int i = 8; i < 14; i++) send_miss(20'h2000 + i * 7);
        check(m_fwd[20'h2000 + 8 * 7] == 16, "R2", "fresh base after replay", 16, 16);
        send_miss(20'h2000 + 10 * 7);
        for (int i = 14; i < 22; i++) send_miss(20'h2000 + i * 7);
        for (int n = 0; n < 60; n++) begin
            k = int'($urandom % 22);
            pf_ready = 1'($urandom);
            send_miss(20'h2000 + k * 7);
        end
        pf_ready = 1'b1;

        // phase A: overflow every set, with one touch part-way (R6 R7)
        do_reset();
        wb_k_q.delete();
        wb_p_q.delete();
        for (int i = 0; i < 64; i++) send_miss(20'h1000 + i);
        check(wb_k_q.size() == 0, "R7", "no writeback before overflow", wb_k_q.size(), 0);
        send_miss(20'h1000 + 13);
        for (int i = 64; i < 80; i++) send_miss(20'h1000 + i);
        check(m_fwd[20'h1000 + 64] == 64, "R2", "realigned base", m_fwd[20'h1000 + 64], 64);
        check(wb_k_q.size() == 16, "R7", "writeback count", wb_k_q.size(), 16);
        for (int i = 64; i < 80; i++) begin
            int es, ep;
            es = (i == 78) ? 30 : i - 64;
            ep = (i == 77) ? 29 : i - 64;
            if (wb_k_q.size() > i - 64) begin
                check(wb_k_q[i - 64] == es, "R6", "LRU victim key", wb_k_q[i - 64], es);
                check(wb_p_q[i - 64] == 20'h1000 + es, "R7", "writeback line",
                      wb_p_q[i - 64], 20'h1000 + es);
            end
            m_rev.delete(es);
            m_fwd.delete(20'h1000 + ep);
        end

        // metadata request dropped while not ready (R9), then reply ignored (R8)
        mreq_ready = 1'b0;
        send_miss(20'h1000 + 13);
        mreq_ready = 1'b1;
        send_rsp(15, 20'h1000 + 15);
        send_miss(20'h1000 + 13);
        send_rsp(77, 20'hBEEF);
        send_rsp(15, 20'h1000 + 15);
        m_rev[15] = 20'h1000 + 15;
        m_fwd[20'h1000 + 15] = 15;
        send_miss(20'h1000 + 76);
        send_miss(20'h1000 + 13);
        send_miss(20'h1000 + 15);
        send_miss(20'h1000 + 78);
        pf_ready = 1'b0;
        send_miss(20'h1000 + 76);
        pf_ready = 1'b1;
        send_miss(20'h1000 + 76);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule